// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block is the interrupt-control section of a small 8-bit processor core. It watches five hardware request lines: a non-maskable trap line, three maskable restart lines (called high, middle and low here) and one general request line whose vector is supplied by the requesting device. It holds a global interrupt-enable flag and a three-bit mask, one bit per restart line. It checks the lines only when the core signals that an instruction has completed.

On each such strobe the block picks the most urgent pending request. One cycle later it raises a single-cycle take pulse, together with a 16-bit vector address and a source code. For the general line it also pulls an active-low acknowledge low, so that the device can place an opcode on the bus. Accepting any maskable request clears the global enable. The core sets the enable again with an explicit command. Through one configuration write the core loads the mask and clears the captured edge of the high restart line.

Top module: `irq_ctrl`

## Requirements
- R1: While reset is asserted and after it: `ien_o`=0, all three restart lines masked, high-line edge latch empty, `take_o`=0, `inta_n_o`=1, `src_o`=0, `vec_o`=0.
- R2: The source chosen at a strobe is the first pending one in this order: trap, high, middle, low, general.
- R3: Source codes and vectors are trap=1 (0x0024), high=2 (0x003C), middle=3 (0x0034), low=4 (0x002C), general=5 (0x0000). `src_o` and `vec_o` change only with a take and hold their value between takes.
- R4: A trap is pending only after a low-to-high change on `trap_i` that is still high at the strobe. It ignores `ien_o` and the mask, leaves `ien_o` unchanged and fires once per rising edge. A pulse that falls before the strobe is lost.
- R5: Restart lines are taken only while `ien_o`=1 and their mask bit is 0. A write with `cfg_data_i[3]`=1 loads the mask from `cfg_data_i[2:0]` (bit 2 high, bit 1 middle, bit 0 low, 1 = masked). A write with bit 3 = 0 leaves the mask unchanged.
- R6: Requests are evaluated only in cycles where `insn_done_i`=1. The take pulse appears in the next cycle and lasts one cycle.
- R7: The general line is gated by `ien_o` only. When it is taken, `inta_n_o` is low for exactly the take cycle.
- R8: `ien_o` goes to 1 one cycle after `ien_set_i`. `ien_clr_i` overrides `ien_set_i`. Accepting a maskable source clears `ien_o` even when `ien_set_i` is high in the same cycle.
- R9: The high line is held by a rising-edge latch. The latch fills even while the line is masked, stays set after the line falls, and empties when that source is taken or on a write with `cfg_data_i[4]`=1. A line that stays high does not fill it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_i | input | 1 | Non-maskable trap request |
| rq_hi_i | input | 1 | High restart request (edge captured) |
| rq_mid_i | input | 1 | Middle restart request (level) |
| rq_lo_i | input | 1 | Low restart request (level) |
| gen_req_i | input | 1 | General request, vector from device |
| insn_done_i | input | 1 | Instruction-complete sample strobe |
| ien_set_i | input | 1 | Enable-interrupts command |
| ien_clr_i | input | 1 | Disable-interrupts command |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_data_i | input | 5 | [2:0] mask, [3] mask load, [4] clear high latch |
| take_o | output | 1 | One-cycle interrupt-accepted pulse |
| src_o | output | 3 | Code of the accepted source |
| vec_o | output | 16 | Vector address of the accepted source |
| inta_n_o | output | 1 | Active-low acknowledge for the general line |
| ien_o | output | 1 | Global interrupt-enable flag |

## Verification
The hardest state to reach is a trap line that has held high past an acceptance while a lower, maskable request is pending. Only this state shows that no second trap is raised and that the lower source wins the next strobe. The stimulus table raises the trap one cycle before a strobe and keeps it high across two back-to-back strobes with the middle line active. A separate trap pulse that falls before its strobe shows that the request is dropped. A second delicate state is an edge captured on the high line while it is masked. The table fills the latch under the mask and strobes once with a write that lacks the load bit. It then unmasks the line and expects the held edge to be taken.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int VEC_W  = 16;
  localparam int NUM_RS = 3;
  localparam int CFG_W  = NUM_RS + 2;
  localparam int MB_HI  = 2;
  localparam int MB_MID = 1;
  localparam int MB_LO  = 0;
  localparam int LOAD_BIT = NUM_RS;
  localparam int CLR_BIT  = NUM_RS + 1;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_TRAP = 3'd1,
    SRC_HI   = 3'd2,
    SRC_MID  = 3'd3,
    SRC_LO   = 3'd4,
    SRC_GEN  = 3'd5
  } src_e;

  localparam logic [VEC_W-1:0] VEC_TRAP = 16'h0024;
  localparam logic [VEC_W-1:0] VEC_HI   = 16'h003C;
  localparam logic [VEC_W-1:0] VEC_MID  = 16'h0034;
  localparam logic [VEC_W-1:0] VEC_LO   = 16'h002C;
  localparam logic [VEC_W-1:0] VEC_GEN  = 16'h0000;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_ns = sh_q[STAGES-1];
endmodule

// File: rtl/irq_rise_latch.sv
module irq_rise_latch #(
  parameter bit NEED_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic clr_i,
  output logic pend_o
);
  logic line_q, held_q, held_d, rise;

  assign rise = line_i & ~line_q;

  generate
    if (NEED_LEVEL) begin : g_level
      // request lost once the line drops before it is taken
      always_comb begin
        held_d = held_q;
        if (rise)                 held_d = 1'b1;
        else if (clr_i || !line_i) held_d = 1'b0;
      end
      assign pend_o = held_q & line_i;
    end else begin : g_hold
      always_comb begin
        held_d = held_q;
        if (rise)       held_d = 1'b1;
        else if (clr_i) held_d = 1'b0;
      end
      assign pend_o = held_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      held_q <= 1'b0;
    end else begin
      line_q <= line_i;
      held_q <= held_d;
    end
  end

  // R9 / R4: a clear without a fresh edge empties the latch
  p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !(line_i && !line_q)) |=> !held_q);
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_pkg::*;
(
  input  logic              trap_p,
  input  logic              hi_p,
  input  logic              mid_p,
  input  logic              lo_p,
  input  logic              gen_p,
  input  logic              ien,
  input  logic [NUM_RS-1:0] mask,
  output logic              hit,
  output logic              maskable,
  output src_e              src,
  output logic [VEC_W-1:0]  vec
);
  always_comb begin
    hit      = 1'b1;
    maskable = 1'b1;
    src      = SRC_NONE;
    vec      = '0;
    if (trap_p) begin
      src = SRC_TRAP; vec = VEC_TRAP; maskable = 1'b0;
    end else if (ien && hi_p && !mask[MB_HI]) begin
      src = SRC_HI;   vec = VEC_HI;
    end else if (ien && mid_p && !mask[MB_MID]) begin
      src = SRC_MID;  vec = VEC_MID;
    end else if (ien && lo_p && !mask[MB_LO]) begin
      src = SRC_LO;   vec = VEC_LO;
    end else if (ien && gen_p) begin
      src = SRC_GEN;  vec = VEC_GEN;
    end else begin
      hit = 1'b0;
      maskable = 1'b0;
    end
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trap_i,
  input  logic             rq_hi_i,
  input  logic             rq_mid_i,
  input  logic             rq_lo_i,
  input  logic             gen_req_i,
  input  logic             insn_done_i,
  input  logic             ien_set_i,
  input  logic             ien_clr_i,
  input  logic             cfg_wr_i,
  input  logic [CFG_W-1:0] cfg_data_i,
  output logic             take_o,
  output logic [2:0]       src_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             inta_n_o,
  output logic             ien_o
);
  logic rst_ns;
  logic trap_p, hi_p, hit, maskable, accept, trap_clr, hi_clr;
  src_e pick_src;
  logic [VEC_W-1:0]  pick_vec;
  logic              ien_q, ien_d;
  logic [NUM_RS-1:0] mask_q, mask_d;
  logic              take_q, take_d, inta_q, inta_d;
  src_e              src_q, src_d;
  logic [VEC_W-1:0]  vec_q, vec_d;

  irq_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_ns(rst_ns));

  irq_rise_latch #(.NEED_LEVEL(1'b1)) u_trap (
    .clk(clk), .rst_n(rst_ns), .line_i(trap_i), .clr_i(trap_clr), .pend_o(trap_p));

  irq_rise_latch #(.NEED_LEVEL(1'b0)) u_hi (
    .clk(clk), .rst_n(rst_ns), .line_i(rq_hi_i), .clr_i(hi_clr), .pend_o(hi_p));

  irq_pick u_pick (
    .trap_p(trap_p), .hi_p(hi_p), .mid_p(rq_mid_i), .lo_p(rq_lo_i),
    .gen_p(gen_req_i), .ien(ien_q), .mask(mask_q), .hit(hit),
    .maskable(maskable), .src(pick_src), .vec(pick_vec));

  assign accept   = insn_done_i & hit;
  assign trap_clr = accept & (pick_src == SRC_TRAP);
  assign hi_clr   = (accept & (pick_src == SRC_HI)) | (cfg_wr_i & cfg_data_i[CLR_BIT]);

  always_comb begin
    ien_d = ien_q;
    if (accept && maskable) ien_d = 1'b0;
    else if (ien_clr_i)     ien_d = 1'b0;
    else if (ien_set_i)     ien_d = 1'b1;

    mask_d = mask_q;
    if (cfg_wr_i && cfg_data_i[LOAD_BIT]) mask_d = cfg_data_i[NUM_RS-1:0];

    take_d = accept;
    inta_d = ~(accept & (pick_src == SRC_GEN));
    src_d  = accept ? pick_src : src_q;
    vec_d  = accept ? pick_vec : vec_q;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      ien_q  <= 1'b0;
      mask_q <= '1;
      take_q <= 1'b0;
      inta_q <= 1'b1;
      src_q  <= SRC_NONE;
      vec_q  <= '0;
    end else begin
      ien_q  <= ien_d;
      mask_q <= mask_d;
      take_q <= take_d;
      inta_q <= inta_d;
      src_q  <= src_d;
      vec_q  <= vec_d;
    end
  end

  assign take_o   = take_q;
  assign src_o    = src_q;
  assign vec_o    = vec_q;
  assign inta_n_o = inta_q;
  assign ien_o    = ien_q;

  // R6: a take only follows a strobe cycle
  p_take_after_strobe_r6: assert property (@(posedge clk) disable iff (!rst_ns)
    take_o |-> $past(insn_done_i));
  // R8: maskable acceptance leaves the global enable cleared
  p_ien_cleared_r8: assert property (@(posedge clk) disable iff (!rst_ns)
    (take_o && src_o != SRC_TRAP) |-> !ien_o);
  // R7: acknowledge only for the general line, only with a take
  p_inta_general_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    !inta_n_o |-> (take_o && src_o == SRC_GEN));
  // R5: middle line taken only when enabled and unmasked
  p_mid_gated_r5: assert property (@(posedge clk) disable iff (!rst_ns)
    (take_o && src_o == SRC_MID) |-> $past(ien_q && !mask_q[MB_MID] && rq_mid_i));
  // R4: a trap take never alters the global enable
  p_trap_keeps_ien_r4: assert property (@(posedge clk) disable iff (!rst_ns)
    (take_o && src_o == SRC_TRAP) |-> (ien_o == $past(ien_o) || $past(ien_set_i || ien_clr_i)));
endmodule

// File: tb/tb_irq_ctrl.sv
module tb_irq_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  logic trap_i, rq_hi_i, rq_mid_i, rq_lo_i, gen_req_i, insn_done_i;
  logic ien_set_i, ien_clr_i, cfg_wr_i;
  logic [4:0]  cfg_data_i;
  logic        take_o, inta_n_o, ien_o;
  logic [2:0]  src_o;
  logic [15:0] vec_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .trap_i(trap_i), .rq_hi_i(rq_hi_i),
    .rq_mid_i(rq_mid_i), .rq_lo_i(rq_lo_i), .gen_req_i(gen_req_i),
    .insn_done_i(insn_done_i), .ien_set_i(ien_set_i), .ien_clr_i(ien_clr_i),
    .cfg_wr_i(cfg_wr_i), .cfg_data_i(cfg_data_i), .take_o(take_o),
    .src_o(src_o), .vec_o(vec_o), .inta_n_o(inta_n_o), .ien_o(ien_o));

  typedef struct packed {
    logic trap, hi, mid, lo, gen, stb, en, dis, wr;
    logic [4:0]  wd;
    logic        take;
    logic [2:0]  src;
    logic [15:0] vec;
    logic        inta_n, ien;
  } row_t;

  localparam int NROWS = 35;
  // columns: trap hi mid lo gen stb en dis wr wd | take src vec inta_n ien
  localparam row_t TBL [NROWS] = '{
    '{1'b0,1'b0,1'b1,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,5'b00000, 1'b0,3'd0,16'h0000,1'b1,1'b0}, // 0 R5 disabled
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b1,5'b01000, 1'b0,3'd0,16'h0000,1'b1,1'b1}, // 1 R8 enable, unmask
    '{1'b0,1'b0,1'b1,1'b1,1'b1, 1'b1,1'b0,1'b0,1'b0,5'b00000, 1'b1,3'd3,16'h0034,1'b1,1'b0}, // 2 R2 mid first
    '{1'b0,1'b0,1'b1,1'b1,1'b1, 1'b1,1'b0,1'b0,1'b0,5'b00000, 1'b0,3'd3,16'h0034,1'b1,1'b0}, // 3 R8 auto-disable
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0,5'b00000, 1'b0,3'd3,16'h0034,1'b1,1'b1}, // 4 R8
    '{1'b0,1'b0,1'b0,1'b1,1'b1, 1'b1,1'b0,1'b0,1'b0,5'b00000, 1'b1,3'd4,16'h002C,1'b1,1'b0}, // 5 R2 low over general
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0,5'b00000, 1'b0,3'd4,16'h002C,1'b1,1'b1}, // 6 R3 hold
    '{1'b0,1'b0,1'b0,1'b0,1'b1, 1'b1,1'b0,1'b0,1'b0,5'b00000, 1'b1,3'd5,16'h0000,1'b0,1'b0}, // 7 R7 general
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b1,5'b01010, 1'b0,3'd5,16'h0000,1'b1,1'b1}, // 8 R7 one-cycle ack
    '{1'b0,1'b0,1'b1,1'b0,1'b1, 1'b1,1'b0,1'b0,1'b0,5'b00000, 1'b1,3'd5,16'h0000,1'b0,1'b0}, // 9 R5 mid masked
    '{1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0,5'b00000, 1'b0,3'd5,16'h0000,1'b1,1'b1}, // 10 R9 edge
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,5'b00000, 1'b1,3'd2,16'h003C,1'b1,1'b0}, // 11 R9 held after fall
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0,5'b00000, 1'b0,3'd2,16'h003C,1'b1,1'b1}, // 12
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,5'b00000, 1'b0,3'd2,16'h003C,1'b1,1'b1}, // 13 R9 serviced clears
    '{1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1,5'b01100, 1'b0,3'd2,16'h003C,1'b1,1'b1}, // 14 R9 edge while masked
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b1,5'b00000, 1'b0,3'd2,16'h003C,1'b1,1'b1}, // 15 R5 no load bit
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1,5'b01000, 1'b0,3'd2,16'h003C,1'b1,1'b1}, // 16 R5 unmask
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,5'b00000, 1'b1,3'd2,16'h003C,1'b1,1'b0}, // 17 R9 kept under mask
    '{1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0,5'b00000, 1'b0,3'd2,16'h003C,1'b1,1'b1}, // 18
    '{1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1,5'b10000, 1'b0,3'd2,16'h003C,1'b1,1'b1}, // 19 R9 clear write
    '{1'b0,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,5'b00000, 1'b0,3'd2,16'h003C,1'b1,1'b1}, // 20 R9 level no refill
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b1,1'b0,5'b00000, 1'b0,3'd2,16'h003C,1'b1,1'b0}, // 21 R8 disable
    '{1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,5'b00000, 1'b0,3'd2,16'h003C,1'b1,1'b0}, // 22 R4 rise
    '{1'b1,1'b0,1'b1,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,5'b00000, 1'b1,3'd1,16'h0024,1'b1,1'b0}, // 23 R4 ignores enable
    '{1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,5'b00000, 1'b0,3'd1,16'h0024,1'b1,1'b0}, // 24 R4 no retake
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,5'b00000, 1'b0,3'd1,16'h0024,1'b1,1'b0}, // 25
    '{1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,5'b00000, 1'b0,3'd1,16'h0024,1'b1,1'b0}, // 26
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,5'b00000, 1'b0,3'd1,16'h0024,1'b1,1'b0}, // 27 R4 pulse lost
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0,5'b00000, 1'b0,3'd1,16'h0024,1'b1,1'b1}, // 28
    '{1'b1,1'b0,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,5'b00000, 1'b0,3'd1,16'h0024,1'b1,1'b1}, // 29 R6 no strobe
    '{1'b1,1'b0,1'b1,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,5'b00000, 1'b1,3'd1,16'h0024,1'b1,1'b1}, // 30 R2 trap over mid
    '{1'b1,1'b0,1'b1,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,5'b00000, 1'b1,3'd3,16'h0034,1'b1,1'b0}, // 31 R4 held trap, mid next
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b1,1'b0,5'b00000, 1'b0,3'd3,16'h0034,1'b1,1'b0}, // 32 R8 disable wins
    '{1'b0,1'b0,1'b0,1'b1,1'b0, 1'b1,1'b1,1'b0,1'b0,5'b00000, 1'b0,3'd3,16'h0034,1'b1,1'b1}, // 33 R8 old enable used
    '{1'b0,1'b0,1'b0,1'b1,1'b0, 1'b1,1'b1,1'b0,1'b0,5'b00000, 1'b1,3'd4,16'h002C,1'b1,1'b0}  // 34 R8 accept beats set
  };

  function automatic string row_tag(int i);
    case (i)
      0, 9, 15, 16:     return "R5";
      2, 5, 30:         return "R2";
      6:                return "R3";
      7, 8:             return "R7";
      10, 11, 12, 13, 14, 17, 18, 19, 20: return "R9";
      22, 23, 24, 25, 26, 27, 31: return "R4";
      29:               return "R6";
      default:          return "R8";
    endcase
  endfunction

  task automatic drive(input row_t r);
    trap_i = r.trap; rq_hi_i = r.hi; rq_mid_i = r.mid; rq_lo_i = r.lo;
    gen_req_i = r.gen; insn_done_i = r.stb; ien_set_i = r.en;
    ien_clr_i = r.dis; cfg_wr_i = r.wr; cfg_data_i = r.wd;
  endtask

  task automatic check(input string tag, input logic tk, input logic [2:0] sr,
                       input logic [15:0] vc, input logic ia, input logic ie);
    n_chk++;
    if (take_o !== tk || src_o !== sr || vec_o !== vc || inta_n_o !== ia || ien_o !== ie) begin
      n_bad++;
      $display("FAIL %s: got take=%b src=%0d vec=%h inta_n=%b ien=%b, expected take=%b src=%0d vec=%h inta_n=%b ien=%b",
               tag, take_o, src_o, vec_o, inta_n_o, ien_o, tk, sr, vc, ia, ie);
    end
  endtask

  localparam row_t IDLE = '{1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,5'b00000,
                            1'b0,3'd0,16'h0000,1'b1,1'b0};

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete, got running expected done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    drive(IDLE);
    repeat (3) @(negedge clk);
    check("R1 reset", 1'b0, 3'd0, 16'h0000, 1'b1, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release", 1'b0, 3'd0, 16'h0000, 1'b1, 1'b0);

    for (int i = 0; i < NROWS; i++) begin
      drive(TBL[i]);
      @(negedge clk);
      check($sformatf("%s row %0d", row_tag(i), i), TBL[i].take, TBL[i].src,
            TBL[i].vec, TBL[i].inta_n, TBL[i].ien);
    end

    // R1: asynchronous reset in mid-run clears outputs, enable and mask
    drive(IDLE);
    ien_set_i = 1'b1;
    @(negedge clk);
    ien_set_i = 1'b0;
    #1 rst_n = 1'b0;
    #1 check("R1 async reset", 1'b0, 3'd0, 16'h0000, 1'b1, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    ien_set_i = 1'b1;
    @(negedge clk);
    ien_set_i = 1'b0;
    check("R1 enable after reset", 1'b0, 3'd0, 16'h0000, 1'b1, 1'b1);
    // mask from reset is all-masked: level restart lines not taken
    rq_mid_i = 1'b1; rq_lo_i = 1'b1; insn_done_i = 1'b1;
    @(negedge clk);
    check("R1 mask after reset", 1'b0, 3'd0, 16'h0000, 1'b1, 1'b1);
    // general line is not masked, only enable-gated (R7)
    rq_mid_i = 1'b0; rq_lo_i = 1'b0; gen_req_i = 1'b1;
    @(negedge clk);
    check("R7 general ignores mask", 1'b1, 3'd5, 16'h0000, 1'b0, 1'b0);
    drive(IDLE);
    @(negedge clk);
    check("R6 single-cycle take", 1'b0, 3'd5, 16'h0000, 1'b1, 1'b0);

    finish_run();
  end
endmodule